// File: doc/BRIEF.md
# Indexed Configuration Register Controller

This block holds a byte-wide configuration space that software reaches through two neighbouring I/O ports. A write to the first port (the pointer port) chooses a register number. A later read or write on the second port (the value port) then reaches that register. Register numbers below 30h form a global area. In that area, register 07h picks which logical device's bank the numbers 30h and above refer to. Two strap pins choose where the port pair sits in the 16-bit I/O space. The straps can also take the pair off the bus entirely.

Each logical device has an enable bit, a base address, an interrupt select, a free configuration byte and a write lock. The enable bits and the lock bits are driven out to the rest of the chip. Device numbers 0 and 1 are always-on functions. They stay enabled, and their banks cannot be reached. Device number 7 and every number above 8 are holes.

There are three reset sources, and each clears a different amount of state. A power-up reset clears everything. A hardware reset clears everything except one keep register. A software reset, started through a global control bit, clears the device banks and the global controls. It spares the pointer, the keep register and any bank whose lock is set.

Top module: `cfg_idx_data_ctrl`

## Requirements
- R1: The strap code sets the port pair. Code 01 gives the pointer at 002Eh and the value at 002Fh. Code 10 gives 015Ch and 015Dh. Codes 00 and 11 disable the pair: no read response, and writes have no effect.
- R2: A read of the pointer port returns the last byte written to it.
- R3: Implemented registers read back the value written. Register 20h is read-only and returns DEV_ID (default E5h). A pointer write in the first clock after reset is released takes effect.
- R4: A value-port read of an unimplemented location returns 00h. Pointers 74h and 75h return 04h for every device number.
- R5: Value writes have no effect when the pointer names no register, when the device number is 0, 1, 7 or above 8, or when the target is read-only. In bank registers, only the implemented bits are stored: enable at 30h bit 0, interrupt select at 70h bits 3:0, lock at F1h bit 0. Base high and low at 60h and 61h and the configuration byte at F0h are full bytes.
- R6: Out of reset, ld_en shows devices 0 and 1 enabled and all others disabled. For devices 2 to 6 and 8, ld_en follows bit 0 of register 30h in that device's bank.
- R7: Writing 1 to bit 1 of register 21h starts a software reset. ld_sw_rst is high for exactly the clock after the write. Bit 1 then clears itself. Register 07h, register 21h and every unlocked bank return to zero. The pointer and register 22h keep their values.
- R8: Writing 1 to bit 0 of F1h locks that bank. Later writes to the bank have no effect, a software reset leaves the bank intact, and ld_lock shows the bit. Only a hardware or power-up reset clears the lock.
- R9: A hardware reset (hw_rst_n low) clears the pointer, the global controls, every bank and every lock. Register 22h keeps its value.
- R10: A power-up reset (por_n low) also clears register 22h.
- R11: A read that hits the port pair raises io_rvld for one clock, starting at the clock edge after the read cycle. io_rdata carries the value during that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| por_n | input | 1 | Power-up reset, active low, asynchronous assert |
| strap_sel | input | 2 | Port pair placement strap |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe, one cycle |
| io_wdata | input | 8 | I/O write byte |
| io_rdata | output | 8 | Read byte |
| io_rvld | output | 1 | Read byte valid |
| ld_en | output | 9 | Per-device enable |
| ld_lock | output | 9 | Per-device lock |
| ld_sw_rst | output | 1 | Software reset pulse to the logical devices |

## Verification
A wrong device number or a wrong pointer sends reads and writes to the wrong bank. The read response one clock later shows the fault: a stored byte comes back as 00h, or a zero comes back as a stale value. Reset reach is checked by writing known bytes into the keep register, an unlocked bank and a locked bank. Each reset type is applied, and the bytes are read back, so a reset that reaches too far or not far enough gives a wrong byte on the first read that follows. Enable and lock faults show at ld_en and ld_lock on the clock after the write.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_DEVID   = 8'h20;
  localparam logic [7:0] IDX_GCTL    = 8'h21;
  localparam logic [7:0] IDX_KEEP    = 8'h22;
  localparam logic [7:0] IDX_BANK_LO = 8'h30;
  localparam logic [7:0] IDX_EN      = 8'h30;
  localparam logic [7:0] IDX_BASEH   = 8'h60;
  localparam logic [7:0] IDX_BASEL   = 8'h61;
  localparam logic [7:0] IDX_IRQ     = 8'h70;
  localparam logic [7:0] IDX_DMA0    = 8'h74;
  localparam logic [7:0] IDX_DMA1    = 8'h75;
  localparam logic [7:0] IDX_DEVCFG  = 8'hF0;
  localparam logic [7:0] IDX_LOCK    = 8'hF1;

  localparam logic [7:0] DMA_NONE    = 8'h04;
  localparam int         GCTL_SWRST  = 1;

  typedef enum logic [1:0] {
    STRAP_OFF_A = 2'b00,
    STRAP_LOW   = 2'b01,
    STRAP_HIGH  = 2'b10,
    STRAP_OFF_B = 2'b11
  } strap_e;

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfgport_pkg::*;
#(
  parameter logic [15:0] BASE_LOW  = 16'h002E,
  parameter logic [15:0] BASE_HIGH = 16'h015C
) (
  input  logic [1:0]  strap_sel,
  input  logic [15:0] addr,
  input  logic        wr,
  input  logic        rd,
  output logic        ptr_wr,
  output logic        ptr_rd,
  output logic        val_wr,
  output logic        val_rd
);

  logic [15:0] base;
  logic        base_vld;
  logic        ptr_hit;
  logic        val_hit;

  always_comb begin
    base     = '0;
    base_vld = 1'b0;
    case (strap_e'(strap_sel))
      STRAP_LOW:  begin base = BASE_LOW;  base_vld = 1'b1; end
      STRAP_HIGH: begin base = BASE_HIGH; base_vld = 1'b1; end
      default:    begin base = '0;        base_vld = 1'b0; end
    endcase
  end

  assign ptr_hit = base_vld && (addr == base);
  assign val_hit = base_vld && (addr == base + 16'd1);

  assign ptr_wr = ptr_hit && wr;
  assign ptr_rd = ptr_hit && rd;
  assign val_wr = val_hit && wr;
  assign val_rd = val_hit && rd;

endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfgport_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'hE5
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] ldn,
  output logic       sw_rst
);

  localparam int CTL_W = 7;

  logic [7:0]       ldn_q, ldn_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             swrst_q, swrst_d;
  logic [7:0]       keep_q, keep_d;
  logic             main_ce;
  logic             keep_ce;
  logic             wr_ldn, wr_gctl, wr_keep;

  assign wr_ldn  = wr_en && (idx == IDX_LDN);
  assign wr_gctl = wr_en && (idx == IDX_GCTL);
  assign wr_keep = wr_en && (idx == IDX_KEEP);

  always_comb begin
    ldn_d   = ldn_q;
    ctl_d   = ctl_q;
    swrst_d = 1'b0;
    if (swrst_q) begin
      ldn_d = '0;
      ctl_d = '0;
    end else begin
      if (wr_ldn) ldn_d = wdata;
      if (wr_gctl) begin
        ctl_d   = {wdata[7:2], wdata[0]};
        swrst_d = wdata[GCTL_SWRST];
      end
    end
    keep_d = wdata;
  end

  assign main_ce = swrst_q || wr_ldn || wr_gctl;
  assign keep_ce = wr_keep;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ldn_q   <= '0;
      ctl_q   <= '0;
      swrst_q <= 1'b0;
    end else if (main_ce) begin
      ldn_q   <= ldn_d;
      ctl_q   <= ctl_d;
      swrst_q <= swrst_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      keep_q <= '0;
    end else if (keep_ce) begin
      keep_q <= keep_d;
    end
  end

  always_comb begin
    case (idx)
      IDX_LDN:   rdata = ldn_q;
      IDX_DEVID: rdata = DEV_ID;
      IDX_GCTL:  rdata = {ctl_q[CTL_W-1:1], swrst_q, ctl_q[0]};
      IDX_KEEP:  rdata = keep_q;
      default:   rdata = 8'h00;
    endcase
  end

  assign ldn    = ldn_q;
  assign sw_rst = swrst_q;

  // R7
  swrst_self_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    swrst_q |=> !swrst_q);

  // R7
  keep_survives_swrst_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (swrst_q && !wr_keep) |=> $stable(keep_q));

  // R7
  ldn_cleared_by_swrst_chk: assert property (@(posedge clk) disable iff (!arst_n)
    swrst_q |=> (ldn_q == 8'h00));

endmodule

// File: rtl/cfg_ld_bank.sv
module cfg_ld_bank
  import cfgport_pkg::*;
#(
  parameter int IRQ_W  = 4,
  parameter int BASE_W = 16
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       sw_rst,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       en_o,
  output logic       lock_o
);

  localparam int BASE_HI_W = BASE_W - 8;

  logic              en_q, en_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [IRQ_W-1:0]  irq_q, irq_d;
  logic [7:0]        cfg_q, cfg_d;
  logic              lock_q, lock_d;
  logic              wr_ok;
  logic              clr;
  logic              ce;

  assign wr_ok = wr_en && !lock_q && !sw_rst;
  assign clr   = sw_rst && !lock_q;
  assign ce    = wr_ok || clr;

  always_comb begin
    en_d   = en_q;
    base_d = base_q;
    irq_d  = irq_q;
    cfg_d  = cfg_q;
    lock_d = lock_q;
    if (clr) begin
      en_d   = 1'b0;
      base_d = '0;
      irq_d  = '0;
      cfg_d  = '0;
    end else if (wr_ok) begin
      case (idx)
        IDX_EN:     en_d = wdata[0];
        IDX_BASEH:  base_d[BASE_W-1:8] = wdata[BASE_HI_W-1:0];
        IDX_BASEL:  base_d[7:0] = wdata;
        IDX_IRQ:    irq_d = wdata[IRQ_W-1:0];
        IDX_DEVCFG: cfg_d = wdata;
        IDX_LOCK:   lock_d = wdata[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      en_q   <= 1'b0;
      base_q <= '0;
      irq_q  <= '0;
      cfg_q  <= '0;
      lock_q <= 1'b0;
    end else if (ce) begin
      en_q   <= en_d;
      base_q <= base_d;
      irq_q  <= irq_d;
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
    end
  end

  always_comb begin
    case (idx)
      IDX_EN:     rdata = {7'b0, en_q};
      IDX_BASEH:  rdata = 8'(base_q[BASE_W-1:8]);
      IDX_BASEL:  rdata = base_q[7:0];
      IDX_IRQ:    rdata = 8'(irq_q);
      IDX_DEVCFG: rdata = cfg_q;
      IDX_LOCK:   rdata = {7'b0, lock_q};
      default:    rdata = 8'h00;
    endcase
  end

  assign en_o   = en_q;
  assign lock_o = lock_q;

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
    lock_q |=> lock_q);

  // R8
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!arst_n)
    lock_q |=> $stable({en_q, base_q, irq_q, cfg_q}));

endmodule

// File: rtl/cfg_idx_data_ctrl.sv
module cfg_idx_data_ctrl
  import cfgport_pkg::*;
#(
  parameter int          NUM_LD    = 9,
  parameter int          HOLE_LD   = 7,
  parameter logic [8:0]  ALWAYS_ON = 9'h003,
  parameter logic [7:0]  DEV_ID    = 8'hE5,
  parameter logic [15:0] BASE_LOW  = 16'h002E,
  parameter logic [15:0] BASE_HIGH = 16'h015C,
  parameter int          IRQ_W     = 4,
  parameter int          BASE_W    = 16
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              por_n,
  input  logic [1:0]        strap_sel,
  input  logic [15:0]       io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvld,
  output logic [NUM_LD-1:0] ld_en,
  output logic [NUM_LD-1:0] ld_lock,
  output logic              ld_sw_rst
);

  logic       arst_n;
  logic       ptr_wr, ptr_rd, val_wr, val_rd;
  logic [7:0] ptr_q, ptr_d;
  logic       glb_area;
  logic       glb_wr, bank_wr;
  logic [7:0] glb_rd, dev_rd, val_byte, rsp_byte;
  logic [7:0] ldn;
  logic       sw_rst;
  logic [7:0] rdata_q, rdata_d;
  logic       rvld_q, rvld_d;
  logic [7:0] bank_rd [NUM_LD];

  assign arst_n = hw_rst_n & por_n;

  cfg_port_decode #(
    .BASE_LOW  (BASE_LOW),
    .BASE_HIGH (BASE_HIGH)
  ) u_decode (
    .strap_sel (strap_sel),
    .addr      (io_addr),
    .wr        (io_wr),
    .rd        (io_rd),
    .ptr_wr    (ptr_wr),
    .ptr_rd    (ptr_rd),
    .val_wr    (val_wr),
    .val_rd    (val_rd)
  );

  assign ptr_d = io_wdata;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ptr_q <= '0;
    end else if (ptr_wr) begin
      ptr_q <= ptr_d;
    end
  end

  assign glb_area = (ptr_q < IDX_BANK_LO);
  assign glb_wr   = val_wr && glb_area;
  assign bank_wr  = val_wr && !glb_area;

  cfg_global_regs #(
    .DEV_ID (DEV_ID)
  ) u_global (
    .clk    (clk),
    .arst_n (arst_n),
    .por_n  (por_n),
    .wr_en  (glb_wr),
    .idx    (ptr_q),
    .wdata  (io_wdata),
    .rdata  (glb_rd),
    .ldn    (ldn),
    .sw_rst (sw_rst)
  );

  for (genvar g = 0; g < NUM_LD; g++) begin : g_ld
    if (g == HOLE_LD || ALWAYS_ON[g]) begin : g_fixed
      assign bank_rd[g] = 8'h00;
      assign ld_en[g]   = ALWAYS_ON[g];
      assign ld_lock[g] = 1'b0;
    end else begin : g_bank
      logic sel;
      assign sel = (ldn == 8'(g));
      cfg_ld_bank #(
        .IRQ_W  (IRQ_W),
        .BASE_W (BASE_W)
      ) u_bank (
        .clk    (clk),
        .arst_n (arst_n),
        .sw_rst (sw_rst),
        .wr_en  (bank_wr && sel),
        .idx    (ptr_q),
        .wdata  (io_wdata),
        .rdata  (bank_rd[g]),
        .en_o   (ld_en[g]),
        .lock_o (ld_lock[g])
      );
    end
  end

  always_comb begin
    dev_rd = 8'h00;
    for (int k = 0; k < NUM_LD; k++) begin
      if (ldn == 8'(k)) dev_rd = bank_rd[k];
    end
  end

  always_comb begin
    if ((ptr_q == IDX_DMA0) || (ptr_q == IDX_DMA1)) val_byte = DMA_NONE;
    else if (glb_area)                              val_byte = glb_rd;
    else                                            val_byte = dev_rd;
  end

  assign rsp_byte = ptr_rd ? ptr_q : val_byte;
  assign rvld_d   = ptr_rd || val_rd;
  assign rdata_d  = rsp_byte;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rvld_q <= 1'b0;
    end else begin
      rvld_q <= rvld_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rdata_q <= '0;
    end else if (rvld_d) begin
      rdata_q <= rdata_d;
    end
  end

  assign io_rdata  = rdata_q;
  assign io_rvld   = rvld_q;
  assign ld_sw_rst = sw_rst;

  // R4
  dma_idle_rsp_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (val_rd && ((ptr_q == IDX_DMA0) || (ptr_q == IDX_DMA1))) |=> (io_rdata == DMA_NONE));

  // R11
  read_latency_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (io_rd && (ptr_rd || val_rd)) |=> io_rvld);

  // R2
  ptr_echo_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (ptr_rd && !ptr_wr) |=> (io_rdata == $past(ptr_q)));

  // R6
  always_on_en_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ((ld_en & ALWAYS_ON) == ALWAYS_ON));

endmodule

// File: tb/cfg_idx_data_ctrl_tb.sv
`timescale 1ns/1ps
module cfg_idx_data_ctrl_tb;

  logic        clk;
  logic        hw_rst_n;
  logic        por_n;
  logic [1:0]  strap_sel;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        io_rvld;
  logic [8:0]  ld_en;
  logic [8:0]  ld_lock;
  logic        ld_sw_rst;

  int          n_vec;
  int          n_bad;
  logic [7:0]  exp_q [$];
  string       tag_q [$];

  localparam logic [15:0] P_LO = 16'h002E;
  localparam logic [15:0] V_LO = 16'h002F;
  localparam logic [15:0] P_HI = 16'h015C;
  localparam logic [15:0] V_HI = 16'h015D;

  cfg_idx_data_ctrl u_dut (
    .clk       (clk),
    .hw_rst_n  (hw_rst_n),
    .por_n     (por_n),
    .strap_sel (strap_sel),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .io_rvld   (io_rvld),
    .ld_en     (ld_en),
    .ld_lock   (ld_lock),
    .ld_sw_rst (ld_sw_rst)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops expected read bytes when the design answers
  always @(negedge clk) begin
    if (hw_rst_n && por_n && io_rvld) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11 unexpected read response: got %h expected none", io_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        if (io_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, io_rdata, e);
        end
      end
    end
  end

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic rd_none(logic [15:0] a, string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    check(tag, {15'b0, io_rvld}, 16'h0000);
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    bus_wr(P_LO, idx);
    bus_wr(V_LO, d);
  endtask

  task automatic reg_rd(logic [7:0] idx, logic [7:0] e, string tag);
    bus_wr(P_LO, idx);
    bus_rd(V_LO, e, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    n_vec = 0; n_bad = 0;
    io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    strap_sel = 2'b01;
    hw_rst_n = 1'b0; por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    hw_rst_n = 1'b1;
    // R3: pointer write in the very first clock after release
    io_addr = P_LO; io_wdata = 8'h22; io_wr = 1'b1;
    check("R6 reset ld_en", {7'b0, ld_en}, 16'h0003);
    check("R8 reset ld_lock", {7'b0, ld_lock}, 16'h0000);
    check("R11 reset rvld", {15'b0, io_rvld}, 16'h0000);
    @(negedge clk);
    io_wr = 1'b0;
    bus_rd(P_LO, 8'h22, "R2 pointer echo after first-cycle write R3");
    bus_wr(V_LO, 8'hA5);
    bus_rd(V_LO, 8'hA5, "R3 keep readback");

    reg_rd(8'h20, 8'hE5, "R3 device id");
    reg_wr(8'h20, 8'h11);
    reg_rd(8'h20, 8'hE5, "R5 device id read-only");
    reg_rd(8'h25, 8'h00, "R4 global hole");

    // device 3
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h07, 8'h03, "R3 ldn readback");
    reg_wr(8'h30, 8'h01);
    check("R6 enable dev3", {7'b0, ld_en}, 16'h000B);
    reg_wr(8'h60, 8'h12);
    reg_wr(8'h61, 8'h34);
    reg_wr(8'h70, 8'h1F);
    reg_wr(8'hF0, 8'h5A);
    reg_rd(8'h60, 8'h12, "R3 base high");
    reg_rd(8'h61, 8'h34, "R3 base low");
    reg_rd(8'h70, 8'h0F, "R5 irq implemented bits");
    reg_rd(8'hF0, 8'h5A, "R3 devcfg");
    reg_rd(8'h74, 8'h04, "R4 idx 74");
    reg_rd(8'h75, 8'h04, "R4 idx 75");
    reg_rd(8'h76, 8'h00, "R4 idx 76");
    reg_wr(8'h31, 8'hFF);
    reg_rd(8'h31, 8'h00, "R5 bank hole write");

    // unreachable device numbers
    reg_wr(8'h07, 8'h07);
    reg_wr(8'h30, 8'h01);
    check("R5 ldn7 enable ignored", {7'b0, ld_en}, 16'h000B);
    reg_rd(8'h30, 8'h00, "R5 ldn7 read");
    reg_rd(8'h74, 8'h04, "R4 ldn7 idx 74");
    reg_wr(8'h07, 8'h09);
    reg_wr(8'h30, 8'h01);
    check("R5 ldn9 enable ignored", {7'b0, ld_en}, 16'h000B);
    reg_rd(8'h30, 8'h00, "R5 ldn9 read");
    reg_wr(8'h07, 8'h00);
    reg_wr(8'h30, 8'h00);
    check("R6 always-on stays", {7'b0, ld_en}, 16'h000B);
    reg_rd(8'h30, 8'h00, "R5 always-on read");

    // device 5 locked
    reg_wr(8'h07, 8'h05);
    reg_wr(8'h30, 8'h01);
    reg_wr(8'hF0, 8'h77);
    reg_wr(8'hF1, 8'h01);
    check("R8 lock out", {7'b0, ld_lock}, 16'h0020);
    reg_rd(8'hF1, 8'h01, "R8 lock readback");
    reg_wr(8'hF0, 8'h00);
    reg_wr(8'h30, 8'h00);
    reg_rd(8'hF0, 8'h77, "R8 locked write ignored");
    check("R8 locked enable held", {7'b0, ld_en}, 16'h002B);

    // software reset
    reg_wr(8'h21, 8'h01);
    reg_rd(8'h21, 8'h01, "R3 gctl readback");
    bus_wr(V_LO, 8'h03);
    check("R7 sw pulse high", {15'b0, ld_sw_rst}, 16'h0001);
    @(negedge clk);
    check("R7 sw pulse low", {15'b0, ld_sw_rst}, 16'h0000);
    bus_rd(P_LO, 8'h21, "R7 pointer kept");
    bus_rd(V_LO, 8'h00, "R7 gctl cleared");
    check("R7 ld_en after swrst", {7'b0, ld_en}, 16'h0023);
    check("R8 lock after swrst", {7'b0, ld_lock}, 16'h0020);
    reg_rd(8'h07, 8'h00, "R7 ldn cleared");
    reg_rd(8'h22, 8'hA5, "R7 keep held");
    reg_wr(8'h07, 8'h05);
    reg_rd(8'hF0, 8'h77, "R8 locked bank survives swrst");
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h60, 8'h00, "R7 unlocked bank cleared");

    // hardware reset
    @(negedge clk);
    hw_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    hw_rst_n = 1'b1;
    check("R9 ld_en", {7'b0, ld_en}, 16'h0003);
    check("R9 ld_lock", {7'b0, ld_lock}, 16'h0000);
    bus_rd(P_LO, 8'h00, "R9 pointer cleared");
    reg_rd(8'h22, 8'hA5, "R9 keep survives");
    reg_wr(8'h07, 8'h05);
    reg_rd(8'hF0, 8'h00, "R9 locked bank cleared");

    // power-up reset
    @(negedge clk);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    reg_rd(8'h22, 8'h00, "R10 keep cleared");

    // strap placement
    bus_wr(P_LO, 8'h22);
    strap_sel = 2'b00;
    bus_wr(P_LO, 8'h99);
    rd_none(P_LO, "R1 strap 00 no response");
    rd_none(V_LO, "R1 strap 00 value no response");
    strap_sel = 2'b01;
    bus_rd(P_LO, 8'h22, "R1 strap 00 write ignored");
    strap_sel = 2'b10;
    bus_wr(P_HI, 8'h07);
    bus_wr(V_HI, 8'h04);
    bus_rd(V_HI, 8'h04, "R1 high base value");
    bus_rd(P_HI, 8'h07, "R1 high base pointer");
    rd_none(P_LO, "R1 low base off when strap 10");
    strap_sel = 2'b11;
    rd_none(P_HI, "R1 strap 11 no response");

    repeat (3) @(negedge clk);
    check("R11 all responses seen", 16'(exp_q.size()), 16'h0000);
    report();
  end

endmodule